// File: doc/BRIEF.md
# Dual-Buffer Serial Flash Command Front End

This block is the serial-side front end of a page-organised flash device that has two SRAM page buffers. A host drives it as an SPI slave in mode 0: it samples data on the rising clock edge and changes data on the falling edge. Each transaction begins with an opcode byte followed by three bytes of address field. Buffer-load commands then stream data bytes into buffer 1 or buffer 2. The write pointer starts at the given byte address and wraps around the end of the buffer. Array commands cover program with erase, program alone, page erase and block erase. The block decodes each of them and hands it to a backend through a one-cycle request port. A request is issued only when chip select returns high after the whole address field has been received.

The SPI pins are synchronised into the system clock domain, so the serial clock must be several system clocks slower than the system clock. A cycle-count timer holds a busy flag for a per-command duration after each request. While the flag is set, every opcode except the status read is dropped. The status read returns one byte, repeated for as long as the host keeps clocking. That byte holds a live ready bit, the result of the last compare as reported by the backend, and a fixed density code. The backend reads buffer contents through a registered read port.

Top module: `spi_dbuf_cmd`

## Requirements
- R1: Opcode 84h loads buffer 1 and 87h loads buffer 2. The 24-bit field after the opcode (MSB first) gives the start byte address in its low 9 bits; its upper 15 bits are ignored. Each later complete byte is stored at the write pointer, and the pointer then advances by one. Buffer contents are read through rd_buf/rd_addr, with rd_data valid one clock later.
- R2: After the byte at location DEPTH-1 the write pointer wraps to 0. Bytes are stored until chip select rises, and a partial byte in flight when chip select rises is discarded.
- R3: A start address at or above DEPTH (default 264) is reduced modulo DEPTH.
- R4: Opcodes 83h/86h request program-with-erase (op_kind 0) and 88h/89h request program-only (op_kind 1). op_buf is 0 for 83h/88h and 1 for 86h/89h. op_page is bits 20..9 of the field; the 3 top bits and 9 low bits are ignored. op_valid is a one-cycle pulse issued after chip select rises, never before.
- R5: Opcode 81h requests a page erase (op_kind 2) with op_page taken from bits 20..9. Opcode 50h requests a block erase (op_kind 3); the block number is bits 20..12, and op_page is the block number followed by three zero bits.
- R6: If chip select rises before all 24 field bits of an array command have arrived, no request is made and busy stays low.
- R7: busy is high for exactly D_EP, D_P, D_PE or D_BE clocks (by op_kind 0..3), starting in the cycle in which op_valid is high.
- R8: After opcode D7h, spi_miso shifts MSB first, repeating the status byte {ready, compare, 1, 0, 0, 0, 0, 0}, where ready = not busy. The ready bit is taken live, so polling sees it change in mid-transaction. Outside a status read spi_miso is 0.
- R9: The compare bit resets to 0, and on each clock with cmp_upd high it takes the value of cmp_miss.
- R10: While busy is high, every opcode except D7h is ignored: buffer loads store nothing and array commands make no request.
- R11: After reset busy, op_valid and spi_miso are 0 and the status byte reads A0h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out (status) |
| op_valid | output | 1 | One-cycle array operation request |
| op_kind | output | 2 | 0 program+erase, 1 program, 2 page erase, 3 block erase |
| op_buf | output | 1 | Source buffer: 0 buffer 1, 1 buffer 2 |
| op_page | output | PAGE_W | Target page (first page of block for erase of a block) |
| busy | output | 1 | Self-timed operation in progress |
| cmp_upd | input | 1 | Backend compare result strobe |
| cmp_miss | input | 1 | Compare result: 1 on mismatch |
| rd_buf | input | 1 | Buffer select for backend read |
| rd_addr | input | BA_W | Byte address for backend read |
| rd_data | output | 8 | Read data, one clock after the address |

## Verification
The bench starts a buffer load two bytes before the end of the buffer and ends it with a partial byte. A design that failed to wrap would write past location 263, and one that committed partial bytes would overwrite the byte after the last complete one. Start addresses above the depth and field bits set in the don't-care and reserved positions are checked as well. Either fault would land data or page numbers in the wrong place.

Commands cut short in the address field must leave no request and no busy period. The bench also checks that no request appears before chip select rises, which catches a decoder that fires on the last address byte. During a long block erase the bench sends loads and erases and confirms that they leave no trace. It then polls status within a single transaction and expects the ready bit to turn over mid-stream, which a design that latches the status once per transaction would miss.

// File: rtl/sdb_pkg.sv
package sdb_pkg;

   typedef enum logic [1:0] {
      OPK_ERPROG = 2'd0,
      OPK_PROG   = 2'd1,
      OPK_PERASE = 2'd2,
      OPK_BERASE = 2'd3
   } opk_e;

   localparam logic [7:0] OPC_LD1  = 8'h84;
   localparam logic [7:0] OPC_LD2  = 8'h87;
   localparam logic [7:0] OPC_EP1  = 8'h83;
   localparam logic [7:0] OPC_EP2  = 8'h86;
   localparam logic [7:0] OPC_PG1  = 8'h88;
   localparam logic [7:0] OPC_PG2  = 8'h89;
   localparam logic [7:0] OPC_PER  = 8'h81;
   localparam logic [7:0] OPC_BER  = 8'h50;
   localparam logic [7:0] OPC_STAT = 8'hD7;

   function automatic logic is_load(input logic [7:0] o);
      return (o == OPC_LD1) || (o == OPC_LD2);
   endfunction

   function automatic logic is_array(input logic [7:0] o);
      return (o == OPC_EP1) || (o == OPC_EP2) || (o == OPC_PG1) ||
             (o == OPC_PG2) || (o == OPC_PER) || (o == OPC_BER);
   endfunction

   function automatic opk_e kind_of(input logic [7:0] o);
      opk_e k;
      case (o)
         OPC_EP1, OPC_EP2: k = OPK_ERPROG;
         OPC_PG1, OPC_PG2: k = OPK_PROG;
         OPC_PER:          k = OPK_PERASE;
         default:          k = OPK_BERASE;
      endcase
      return k;
   endfunction

   function automatic logic buf_of(input logic [7:0] o);
      return (o == OPC_EP2) || (o == OPC_PG2) || (o == OPC_LD2);
   endfunction

endpackage

// File: rtl/sdb_spi_rx.sv
module sdb_spi_rx #(
   parameter int SYNC = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       spi_sck,
   input  logic       spi_cs_n,
   input  logic       spi_mosi,
   output logic       cs_s,
   output logic       cs_rise,
   output logic       sck_fall,
   output logic       byte_done,
   output logic [7:0] rx_byte,
   output logic [2:0] bit_cnt
);

   // stage vector: [2] sck, [1] cs_n, [0] mosi
   localparam logic [2:0] IDLE_PINS = 3'b010;

   logic [2:0] stg [SYNC];
   logic       sck_s, mosi_s, sck_d, cs_d, sck_rise;
   logic [6:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= IDLE_PINS;
      else        stg[0] <= {spi_sck, spi_cs_n, spi_mosi};
   end

   for (genvar i = 1; i < SYNC; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[i] <= IDLE_PINS;
         else        stg[i] <= stg[i-1];
      end
   end

   assign sck_s  = stg[SYNC-1][2];
   assign cs_s   = stg[SYNC-1][1];
   assign mosi_s = stg[SYNC-1][0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d <= 1'b0;
         cs_d  <= 1'b1;
      end else begin
         sck_d <= sck_s;
         cs_d  <= cs_s;
      end
   end

   assign sck_rise  = sck_s & ~sck_d & ~cs_s;
   assign sck_fall  = ~sck_s & sck_d & ~cs_s;
   assign cs_rise   = cs_s & ~cs_d;
   assign rx_byte   = {sh, mosi_s};
   assign byte_done = sck_rise && (bit_cnt == 3'd7);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh      <= '0;
         bit_cnt <= '0;
      end else if (cs_s) begin
         bit_cnt <= '0;
      end else if (sck_rise) begin
         sh      <= {sh[5:0], mosi_s};
         bit_cnt <= bit_cnt + 3'd1;
      end
   end

endmodule

// File: rtl/sdb_cmd_dec.sv
module sdb_cmd_dec
   import sdb_pkg::*;
#(
   parameter int DEPTH  = 264,
   parameter int BA_W   = 9,
   parameter int PAGE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s,
   input  logic              cs_rise,
   input  logic              byte_done,
   input  logic [7:0]        rx_byte,
   input  logic              busy,
   output logic              wr_en,
   output logic              wr_sel,
   output logic [BA_W-1:0]   wr_addr,
   output logic [7:0]        wr_data,
   output logic              launch,
   output opk_e              launch_kind,
   output logic              stat_mode,
   output logic              stat_start,
   output logic              op_valid,
   output logic [1:0]        op_kind,
   output logic              op_buf,
   output logic [PAGE_W-1:0] op_page
);

   localparam int FLD_W     = 3 + PAGE_W + BA_W;
   localparam int FLD_BYTES = FLD_W / 8;
   localparam int KEEP_W    = FLD_W - 3;
   localparam int BLK_W     = PAGE_W - 3;
   localparam int CNT_W     = $clog2(FLD_BYTES + 1);

   typedef enum logic [2:0] {
      S_OPC, S_ADDR, S_DATA, S_ARM, S_STAT, S_DROP
   } st_e;

   st_e              st;
   logic [7:0]       opc;
   logic [KEEP_W-1:0] fld, fld_next;
   logic [CNT_W-1:0] acnt;
   logic [BA_W-1:0]  wptr, ptr_nxt, start_ptr;
   logic [PAGE_W-1:0] page_sel;

   assign fld_next  = {fld[KEEP_W-9:0], rx_byte};
   assign start_ptr = BA_W'(32'(fld_next[BA_W-1:0]) % DEPTH);
   assign ptr_nxt   = (wptr == BA_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;

   assign launch      = cs_rise && (st == S_ARM);
   assign launch_kind = kind_of(opc);

   always_comb begin
      if (launch_kind == OPK_BERASE)
         page_sel = {fld[BA_W+PAGE_W-1 -: BLK_W], 3'b000};
      else
         page_sel = fld[BA_W+PAGE_W-1 -: PAGE_W];
   end

   assign wr_en      = byte_done && (st == S_DATA);
   assign wr_sel     = buf_of(opc);
   assign wr_addr    = wptr;
   assign wr_data    = rx_byte;
   assign stat_mode  = (st == S_STAT);
   assign stat_start = byte_done && (st == S_OPC) && (rx_byte == OPC_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_valid <= 1'b0;
         op_kind  <= '0;
         op_buf   <= 1'b0;
         op_page  <= '0;
      end else begin
         op_valid <= launch;
         if (launch) begin
            op_kind <= launch_kind;
            op_buf  <= buf_of(opc);
            op_page <= page_sel;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= S_OPC;
         opc  <= '0;
         fld  <= '0;
         acnt <= '0;
         wptr <= '0;
      end else if (cs_s) begin
         st   <= S_OPC;
         acnt <= '0;
      end else if (byte_done) begin
         case (st)
            S_OPC: begin
               opc  <= rx_byte;
               acnt <= '0;
               if (rx_byte == OPC_STAT)
                  st <= S_STAT;
               else if (!busy && (is_load(rx_byte) || is_array(rx_byte)))
                  st <= S_ADDR;
               else
                  st <= S_DROP;
            end
            S_ADDR: begin
               fld  <= fld_next;
               acnt <= acnt + 1'b1;
               if (acnt == CNT_W'(FLD_BYTES - 1)) begin
                  if (is_load(opc)) begin
                     st   <= S_DATA;
                     wptr <= start_ptr;
                  end else begin
                     st <= S_ARM;
                  end
               end
            end
            S_DATA:  wptr <= ptr_nxt;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/sdb_dbuf.sv
module sdb_dbuf #(
   parameter int DEPTH = 264,
   parameter int BA_W  = 9,
   parameter int NBUF  = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic            wr_sel,
   input  logic [BA_W-1:0] wr_addr,
   input  logic [7:0]      wr_data,
   input  logic            rd_buf,
   input  logic [BA_W-1:0] rd_addr,
   output logic [7:0]      rd_data
);

   logic [7:0] q [NBUF];
   logic       sel_q;

   for (genvar g = 0; g < NBUF; g++) begin : g_bank
      logic [7:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (wr_en && (32'(wr_sel) == g))
            mem[wr_addr] <= wr_data;
         q[g] <= mem[rd_addr];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= 1'b0;
      else        sel_q <= rd_buf;
   end

   assign rd_data = q[sel_q];

endmodule

// File: rtl/sdb_stat_tmr.sv
module sdb_stat_tmr
   import sdb_pkg::*;
#(
   parameter int unsigned D_EP = 400,
   parameter int unsigned D_P  = 300,
   parameter int unsigned D_PE = 200,
   parameter int unsigned D_BE = 600
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       launch,
   input  opk_e       launch_kind,
   input  logic       cmp_upd,
   input  logic       cmp_miss,
   input  logic       stat_mode,
   input  logic       stat_start,
   input  logic       sck_fall,
   input  logic [2:0] bit_cnt,
   output logic       busy,
   output logic       spi_miso
);

   localparam int unsigned MAX_A = (D_EP > D_P) ? D_EP : D_P;
   localparam int unsigned MAX_B = (D_PE > D_BE) ? D_PE : D_BE;
   localparam int unsigned D_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int          CW    = $clog2(D_MAX + 1);

   logic [CW-1:0] cnt, dur;
   logic          comp;
   logic [2:0]    tx_idx;
   logic [7:0]    stat_byte;

   always_comb begin
      case (launch_kind)
         OPK_ERPROG: dur = CW'(D_EP);
         OPK_PROG:   dur = CW'(D_P);
         OPK_PERASE: dur = CW'(D_PE);
         default:    dur = CW'(D_BE);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (launch)     cnt <= dur;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       comp <= 1'b0;
      else if (cmp_upd) comp <= cmp_miss;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          tx_idx <= '0;
      else if (stat_start) tx_idx <= '0;
      else if (sck_fall)   tx_idx <= bit_cnt;
   end

   assign stat_byte = {~busy, comp, 3'b100, 3'b000};
   assign spi_miso  = stat_mode && stat_byte[3'd7 - tx_idx];

endmodule

// File: rtl/spi_dbuf_cmd.sv
module spi_dbuf_cmd
   import sdb_pkg::*;
#(
   parameter int          DEPTH  = 264,
   parameter int          BA_W   = 9,
   parameter int          PAGE_W = 12,
   parameter int          SYNC   = 2,
   parameter int unsigned D_EP   = 400,
   parameter int unsigned D_P    = 300,
   parameter int unsigned D_PE   = 200,
   parameter int unsigned D_BE   = 600
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              op_valid,
   output logic [1:0]        op_kind,
   output logic              op_buf,
   output logic [PAGE_W-1:0] op_page,
   output logic              busy,
   input  logic              cmp_upd,
   input  logic              cmp_miss,
   input  logic              rd_buf,
   input  logic [BA_W-1:0]   rd_addr,
   output logic [7:0]        rd_data
);

   if (DEPTH < 2 || DEPTH > (1 << BA_W)) begin : g_bad_depth
      $error("DEPTH must lie in 2 .. 2**BA_W");
   end
   if (((3 + PAGE_W + BA_W) % 8) != 0) begin : g_bad_field
      $error("address field must be a whole number of bytes");
   end
   if (PAGE_W < 4 || BA_W < 8) begin : g_bad_width
      $error("PAGE_W must be >= 4 and BA_W >= 8");
   end
   if (SYNC < 2) begin : g_bad_sync
      $error("SYNC must be at least 2");
   end
   if (D_EP < 1 || D_P < 1 || D_PE < 1 || D_BE < 1) begin : g_bad_dur
      $error("durations must be at least one cycle");
   end

   logic            cs_s, cs_rise, sck_fall, byte_done;
   logic [7:0]      rx_byte;
   logic [2:0]      bit_cnt;
   logic            wr_en, wr_sel;
   logic [BA_W-1:0] wr_addr;
   logic [7:0]      wr_data;
   logic            launch, stat_mode, stat_start;
   opk_e            launch_kind;

   sdb_spi_rx #(.SYNC(SYNC)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
      .cs_s(cs_s), .cs_rise(cs_rise), .sck_fall(sck_fall),
      .byte_done(byte_done), .rx_byte(rx_byte), .bit_cnt(bit_cnt)
   );

   sdb_cmd_dec #(.DEPTH(DEPTH), .BA_W(BA_W), .PAGE_W(PAGE_W)) u_dec (
      .clk(clk), .rst_n(rst_n),
      .cs_s(cs_s), .cs_rise(cs_rise), .byte_done(byte_done),
      .rx_byte(rx_byte), .busy(busy),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
      .launch(launch), .launch_kind(launch_kind),
      .stat_mode(stat_mode), .stat_start(stat_start),
      .op_valid(op_valid), .op_kind(op_kind), .op_buf(op_buf), .op_page(op_page)
   );

   sdb_dbuf #(.DEPTH(DEPTH), .BA_W(BA_W), .NBUF(2)) u_buf (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_buf(rd_buf), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   sdb_stat_tmr #(.D_EP(D_EP), .D_P(D_P), .D_PE(D_PE), .D_BE(D_BE)) u_st (
      .clk(clk), .rst_n(rst_n),
      .launch(launch), .launch_kind(launch_kind),
      .cmp_upd(cmp_upd), .cmp_miss(cmp_miss),
      .stat_mode(stat_mode), .stat_start(stat_start),
      .sck_fall(sck_fall), .bit_cnt(bit_cnt),
      .busy(busy), .spi_miso(spi_miso)
   );

endmodule

// File: rtl/sdb_chk.sv
module sdb_chk #(
   parameter int          PAGE_W = 12,
   parameter int unsigned D_EP   = 400,
   parameter int unsigned D_P    = 300,
   parameter int unsigned D_PE   = 200,
   parameter int unsigned D_BE   = 600
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [1:0]        op_kind,
   input logic [PAGE_W-1:0] op_page,
   input logic              busy,
   input logic              spi_miso,
   input logic              cs_s
);

   int unsigned run_len, run_exp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_len <= 0;
         run_exp <= 0;
      end else if (op_valid) begin
         run_len <= 1;
         case (op_kind)
            2'd0:    run_exp <= D_EP;
            2'd1:    run_exp <= D_P;
            2'd2:    run_exp <= D_PE;
            default: run_exp <= D_BE;
         endcase
      end else if (busy) begin
         run_len <= run_len + 1;
      end
   end

   AST_OP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> !op_valid);                                       // R4
   AST_OP_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |-> $past(cs_s));                                     // R4
   AST_OP_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |-> !$past(busy));                                    // R10
   AST_BUSY_WITH_OP: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |-> busy);                                            // R7
   AST_BLOCK_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_kind == 2'd3) |-> (op_page[2:0] == 3'd0));     // R5
   AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && !busy) |-> (run_len == run_exp));              // R7
   AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cs_s) && cs_s) |-> !spi_miso);                          // R8

endmodule

bind spi_dbuf_cmd sdb_chk #(
   .PAGE_W(PAGE_W), .D_EP(D_EP), .D_P(D_P), .D_PE(D_PE), .D_BE(D_BE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
   .op_page(op_page), .busy(busy), .spi_miso(spi_miso), .cs_s(cs_s)
);

// File: tb/sim_spi_dbuf_cmd.sv
module sim_spi_dbuf_cmd;

   localparam int CLK_P = 10;
   localparam int HALF  = 6;
   localparam int DEPTH = 264;
   localparam int D_EP  = 50;
   localparam int D_P   = 40;
   localparam int D_PE  = 30;
   localparam int D_BE  = 3000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   logic miso, op_valid, op_buf, busy;
   logic [1:0] op_kind;
   logic [11:0] op_page;
   logic cmp_upd = 1'b0, cmp_miss = 1'b0;
   logic rd_bsel = 1'b0;
   logic [8:0] rd_addr = '0;
   logic [7:0] rd_data;

   int total = 0, bad = 0;
   int n_ops = 0, run = 0;
   logic [1:0]  cap_kind;
   logic        cap_buf;
   logic [11:0] cap_page;

   spi_dbuf_cmd #(.DEPTH(DEPTH), .D_EP(D_EP), .D_P(D_P), .D_PE(D_PE), .D_BE(D_BE)) u0 (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
      .spi_miso(miso), .op_valid(op_valid), .op_kind(op_kind), .op_buf(op_buf),
      .op_page(op_page), .busy(busy), .cmp_upd(cmp_upd), .cmp_miss(cmp_miss),
      .rd_buf(rd_bsel), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   always #(CLK_P/2) clk = ~clk;

   always @(negedge clk) begin
      if (rst_n) begin
         if (op_valid) begin
            n_ops++;
            cap_kind = op_kind;
            cap_buf  = op_buf;
            cap_page = op_page;
            run = 1;
         end else if (busy) begin
            run++;
         end
      end
   end

   task automatic summary;
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cs_begin;
      tick(2); cs_n = 1'b0; tick(HALF + 4);
   endtask

   task automatic cs_end;
      tick(HALF); cs_n = 1'b1; tick(HALF + 6);
   endtask

   task automatic spi_byte(input logic [7:0] b, output logic [7:0] r);
      for (int i = 7; i >= 0; i--) begin
         mosi = b[i];
         tick(HALF);
         r[i] = miso;
         sck = 1'b1;
         tick(HALF);
         sck = 1'b0;
      end
   endtask

   task automatic spi_bits(input int n);
      for (int i = 0; i < n; i++) begin
         mosi = 1'b1; tick(HALF); sck = 1'b1; tick(HALF); sck = 1'b0;
      end
   endtask

   task automatic send_hdr(input logic [7:0] opc, input logic [23:0] fld, input int nb);
      logic [7:0] d;
      spi_byte(opc, d);
      if (nb > 0) spi_byte(fld[23:16], d);
      if (nb > 1) spi_byte(fld[15:8], d);
      if (nb > 2) spi_byte(fld[7:0], d);
   endtask

   task automatic load(input logic [7:0] opc, input logic [23:0] fld,
                       input logic [7:0] d0, input logic [7:0] d1, input int nd);
      logic [7:0] d;
      cs_begin;
      send_hdr(opc, fld, 3);
      if (nd > 0) spi_byte(d0, d);
      if (nd > 1) spi_byte(d1, d);
      cs_end;
   endtask

   task automatic stat_read(output logic [7:0] s);
      logic [7:0] d;
      cs_begin;
      spi_byte(8'hD7, d);
      spi_byte(8'h00, s);
      cs_end;
   endtask

   task automatic rd(input logic bs, input logic [8:0] a, output logic [7:0] v);
      rd_bsel = bs; rd_addr = a;
      tick(1);
      v = rd_data;
   endtask

   task automatic wait_idle;
      while (busy) tick(1);
      tick(2);
   endtask

   task automatic t_reset;
      logic [7:0] s;
      chk("R11 busy", busy, 0);
      chk("R11 op_valid", op_valid, 0);
      chk("R11 miso", miso, 0);
      stat_read(s);
      chk("R11 R8 status after reset", s, 8'hA0);
   endtask

   task automatic t_load;
      logic [7:0] v, d;
      cs_begin;
      send_hdr(8'h84, 24'hFFFE05, 3);
      spi_byte(8'h11, d); spi_byte(8'h22, d); spi_byte(8'h33, d); spi_byte(8'h44, d);
      cs_end;
      load(8'h87, 24'h000005, 8'hAA, 8'hBB, 2);
      rd(0, 9'd5, v); chk("R1 buf1[5]", v, 8'h11);
      rd(0, 9'd8, v); chk("R1 buf1[8]", v, 8'h44);
      rd(1, 9'd5, v); chk("R1 buf2[5]", v, 8'hAA);
      rd(1, 9'd6, v); chk("R1 buf2[6]", v, 8'hBB);
   endtask

   task automatic t_wrap;
      logic [7:0] v, d;
      load(8'h84, 24'h000002, 8'h77, 8'h00, 1);
      cs_begin;
      send_hdr(8'h84, 24'd262, 3);
      spi_byte(8'hC1, d); spi_byte(8'hC2, d); spi_byte(8'hC3, d); spi_byte(8'hC4, d);
      spi_bits(3);
      cs_end;
      rd(0, 9'd262, v); chk("R2 buf1[262]", v, 8'hC1);
      rd(0, 9'd263, v); chk("R2 buf1[263]", v, 8'hC2);
      rd(0, 9'd0, v);   chk("R2 wrap buf1[0]", v, 8'hC3);
      rd(0, 9'd1, v);   chk("R2 wrap buf1[1]", v, 8'hC4);
      rd(0, 9'd2, v);   chk("R2 partial byte dropped", v, 8'h77);
   endtask

   task automatic t_mod;
      logic [7:0] v;
      load(8'h87, 24'd300, 8'h5E, 8'h00, 1);
      load(8'h87, 24'd511, 8'h6F, 8'h00, 1);
      rd(1, 9'd36, v);  chk("R3 300 mod 264", v, 8'h5E);
      rd(1, 9'd247, v); chk("R3 511 mod 264", v, 8'h6F);
   endtask

   task automatic arr(input logic [7:0] opc, input logic [23:0] fld,
                      input logic [1:0] k, input logic b, input logic [11:0] pg,
                      input int dur, input string tag);
      int n0;
      n0 = n_ops;
      cs_begin;
      send_hdr(opc, fld, 3);
      tick(HALF + 6);
      chk({tag, " no request before cs rise"}, n_ops, n0);
      cs_end;
      chk({tag, " request count"}, n_ops, n0 + 1);
      chk({tag, " kind"}, cap_kind, k);
      chk({tag, " buffer"}, cap_buf, b);
      chk({tag, " page"}, cap_page, pg);
      wait_idle;
      chk({tag, " R7 busy length"}, run, dur);
   endtask

   task automatic t_prog;
      arr(8'h83, 24'h157800, 2'd0, 1'b0, 12'hABC, D_EP, "R4 83h");
      arr(8'h89, 24'hE247FF, 2'd1, 1'b1, 12'h123, D_P,  "R4 89h");
      arr(8'h86, 24'h000200, 2'd0, 1'b1, 12'h001, D_EP, "R4 86h");
   endtask

   task automatic t_erase;
      arr(8'h81, 24'h0FFE00, 2'd2, 1'b0, 12'h7FF, D_PE, "R5 81h");
   endtask

   task automatic t_abort;
      int n0;
      n0 = n_ops;
      cs_begin; send_hdr(8'h83, 24'h157800, 2); cs_end;
      cs_begin; send_hdr(8'h50, 24'h1ABFFF, 0); cs_end;
      cs_begin; send_hdr(8'h81, 24'h0FFE00, 2); spi_bits(7); cs_end;
      chk("R6 no request on short field", n_ops, n0);
      chk("R6 no busy on short field", busy, 0);
   endtask

   task automatic t_busy;
      logic [7:0] s, d, v;
      int n0;
      bit saw_busy;
      load(8'h84, 24'd20, 8'h11, 8'h00, 1);
      cs_begin; send_hdr(8'h50, 24'h1ABFFF, 3); cs_end;
      chk("R5 block kind", cap_kind, 2'd3);
      chk("R5 block page", cap_page, 12'hD58);
      stat_read(s);
      chk("R8 status while busy", s, 8'h20);
      n0 = n_ops;
      load(8'h84, 24'd20, 8'h5A, 8'h00, 1);
      cs_begin; send_hdr(8'h81, 24'h0FFE00, 3); cs_end;
      chk("R10 no request while busy", n_ops, n0);
      saw_busy = 0;
      cs_begin;
      spi_byte(8'hD7, d);
      for (int i = 0; i < 60; i++) begin
         spi_byte(8'h00, s);
         if (s == 8'h20) saw_busy = 1;
         if (s[7]) break;
      end
      cs_end;
      chk("R8 polling saw busy", saw_busy, 1);
      chk("R8 polling ends ready", s, 8'hA0);
      wait_idle;
      chk("R7 block busy length", run, D_BE);
      rd(0, 9'd20, v);
      chk("R10 load while busy ignored", v, 8'h11);
   endtask

   task automatic t_cmp;
      logic [7:0] s;
      tick(1); cmp_miss = 1'b1; cmp_upd = 1'b1; tick(1); cmp_upd = 1'b0; cmp_miss = 1'b0;
      stat_read(s);
      chk("R9 compare mismatch", s, 8'hE0);
      tick(1); cmp_upd = 1'b1; tick(1); cmp_upd = 1'b0;
      stat_read(s);
      chk("R9 compare match", s, 8'hA0);
   endtask

   initial begin
      #(CLK_P * 150000);
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      summary;
      $finish;
   end

   initial begin
      tick(5);
      rst_n = 1'b1;
      tick(3);
      t_reset;
      t_load;
      t_wrap;
      t_mod;
      t_prog;
      t_erase;
      t_abort;
      t_busy;
      t_cmp;
      summary;
      $finish;
   end

endmodule